// File: doc/BRIEF.md
# Bus Fault Capture Register

This block holds a 16-bit fault word that gathers error conditions reported by memory, address decoders and system monitors. Memory-side error lines are active low. The block samples them at one moment only: the clock edge where it sees the active-low bus-busy line go back high, which marks the end of a bus cycle. It samples on every bus cycle, including cycles driven by another bus master. The ownership and cycle-type qualifiers present at that edge decide which bit each error sets.

Two system fault lines are asynchronous to the clock. Each passes through a synchronizer and sets its bits on a rising edge. All bits stay set until software pulses a clear strobe. The block has three summary outputs. A fault-pending output reflects any set bit. A major-error output and an unrecoverable-error output each reflect a set bit under a parameter mask. Bit numbering treats bit 0 as the most significant bit, so bit n sits at vector position 15-n.

Top module: `bus_fault_reg`

## Requirements
- R1: After reset the fault word is 0x0000, and pending, major and unrecoverable all read 0.
- R2: Error inputs change the fault word only at a clock edge where busy_n is sampled high and was sampled low at the edge before. Errors held while busy_n stays low, or while it stays high, set nothing.
- R3: A protect error (prot_err_n low) at the end of a cycle sets bit 0 (0x8000) when own_cycle is 1. It sets bit 1 (0x4000) when own_cycle is 0.
- R4: A parity error (par_err_n low) at the end of a cycle sets bit 2 (0x2000), whatever the ownership and the cycle type.
- R5: An address error (addr_err_n low) at the end of a cycle sets bit 5 (0x0400) when io_cycle is 0 (memory). It sets bit 8 (0x0080) when io_cycle is 1 (I/O). Ownership does not change the bit.
- R6: A rising edge on sysflt0 sets bit 7 (0x0100). The bit is visible after the third clock edge that follows the rise. Holding sysflt0 high after a clear does not set the bit again.
- R7: A rising edge on sysflt1 sets bits 13 and 15 together (0x0005), with the same latency as R6.
- R8: Set bits stay set through idle cycles. A clr_stb pulse with no set event at the same edge returns the word to 0x0000 at the next edge.
- R9: A set event at the same edge as clr_stb wins. After that edge the word holds only the newly set bits.
- R10: pending is 1 exactly when the fault word is non-zero.
- R11: major_err is 1 when the word ANDed with MAJOR_MASK is non-zero. The default MAJOR_MASK is 0xE480 (bits 0, 1, 2, 5 and 8). unrcv_err is 1 when the word ANDed with UNRCV_MASK is non-zero. The default UNRCV_MASK is 0x0105 (bits 7, 13 and 15).
- R12: Several errors present at the same cycle end all set their bits in that one update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy_n | input | 1 | Active-low bus-busy; its rise ends a bus cycle |
| own_cycle | input | 1 | 1 when the ending cycle belongs to this CPU |
| io_cycle | input | 1 | 1 for an I/O cycle, 0 for a memory cycle |
| prot_err_n | input | 1 | Active-low memory protect error |
| par_err_n | input | 1 | Active-low memory parity error |
| addr_err_n | input | 1 | Active-low external address error |
| sysflt0 | input | 1 | Asynchronous system fault, rising-edge active |
| sysflt1 | input | 1 | Asynchronous system fault, rising-edge active |
| clr_stb | input | 1 | One-cycle clear strobe from software |
| fault_q | output | 16 | Fault word, bit 0 at position 15 |
| pending | output | 1 | Any fault bit set |
| major_err | output | 1 | Any bit under MAJOR_MASK set |
| unrcv_err | output | 1 | Any bit under UNRCV_MASK set |

## Verification
The bench holds error lines active across many edges while busy_n is still low. A design that samples the level instead of the rise would latch faults early. It checks that protect errors from cycles owned by another master still land, and in bit 1 rather than bit 0. A design that ignores cycles it does not own, or that ignores ownership, would show a missing or misplaced bit. It also checks that the address error follows the memory or I/O qualifier, that a fault collides correctly with a clear at the same edge, and that a system fault held high stays quiet after a clear. A clear that wins the collision, or a level-triggered system fault, would show up as a wrong word in those checks.

// File: rtl/bus_fault_reg.sv
module bus_fault_reg #(
  parameter logic [15:0] MAJOR_MASK  = 16'hE480,
  parameter logic [15:0] UNRCV_MASK  = 16'h0105,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        busy_n,
  input  logic        own_cycle,
  input  logic        io_cycle,
  input  logic        prot_err_n,
  input  logic        par_err_n,
  input  logic        addr_err_n,
  input  logic        sysflt0,
  input  logic        sysflt1,
  input  logic        clr_stb,
  output logic [15:0] fault_q,
  output logic        pending,
  output logic        major_err,
  output logic        unrcv_err
);

  localparam int W = 16;
  localparam int NSYS = 2;

  function automatic logic [W-1:0] fbit(input int n);
    return {{(W-1){1'b0}}, 1'b1} << (W - 1 - n);
  endfunction

  localparam logic [W-1:0] B_PROT_OWN = fbit(0);
  localparam logic [W-1:0] B_PROT_EXT = fbit(1);
  localparam logic [W-1:0] B_PARITY   = fbit(2);
  localparam logic [W-1:0] B_ADR_MEM  = fbit(5);
  localparam logic [W-1:0] B_SYS0     = fbit(7);
  localparam logic [W-1:0] B_ADR_IO   = fbit(8);
  localparam logic [W-1:0] B_SYS1     = fbit(13) | fbit(15);

  logic busy_q;
  logic busy_rise;
  logic [NSYS-1:0] sys_in;
  logic [NSYS-1:0] sys_rise;
  logic [W-1:0] bus_set, sys_set, fault_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) busy_q <= 1'b1;
    else        busy_q <= busy_n;

  assign busy_rise = ~busy_q & busy_n;
  assign sys_in = {sysflt1, sysflt0};

  for (genvar g = 0; g < NSYS; g++) begin : g_sync
    logic [SYNC_STAGES:0] sh;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sh <= '0;
      else        sh <= {sh[SYNC_STAGES-1:0], sys_in[g]};
    assign sys_rise[g] = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
  end

  always_comb begin
    bus_set = '0;
    if (busy_rise) begin
      if (!prot_err_n) bus_set |= own_cycle ? B_PROT_OWN : B_PROT_EXT;
      if (!par_err_n)  bus_set |= B_PARITY;
      if (!addr_err_n) bus_set |= io_cycle ? B_ADR_IO : B_ADR_MEM;
    end
  end

  assign sys_set = (sys_rise[0] ? B_SYS0 : '0) | (sys_rise[1] ? B_SYS1 : '0);
  assign fault_d = (clr_stb ? '0 : fault_q) | bus_set | sys_set;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fault_q <= '0;
    else        fault_q <= fault_d;

  assign pending   = |fault_q;
  assign major_err = |(fault_q & MAJOR_MASK);
  assign unrcv_err = |(fault_q & UNRCV_MASK);

endmodule

module bus_fault_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy_n,
  input logic        own_cycle,
  input logic        prot_err_n,
  input logic        clr_stb,
  input logic [15:0] fault_q,
  input logic        pending,
  input logic        major_err
);
  logic busy_prev;
  logic end_edge;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) busy_prev <= 1'b1;
    else        busy_prev <= busy_n;

  assign end_edge = ~busy_prev & busy_n;

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_stb |=> ((fault_q & $past(fault_q)) == $past(fault_q)));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_stb && !end_edge) |=> ((fault_q & 16'hFEFA) == 16'h0000));

  p_own_prot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (end_edge && !prot_err_n && own_cycle) |=> fault_q[15]);

  p_ext_prot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (end_edge && !prot_err_n && !own_cycle) |=> fault_q[14]);

  p_pending_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> $past(clr_stb));

  p_major_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
    major_err |-> pending);
endmodule

bind bus_fault_reg bus_fault_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy_n(busy_n), .own_cycle(own_cycle),
  .prot_err_n(prot_err_n), .clr_stb(clr_stb), .fault_q(fault_q),
  .pending(pending), .major_err(major_err)
);

// File: tb/bus_fault_reg_test.sv
module bus_fault_reg_test;
  localparam logic [15:0] MAJ = 16'hE480;
  localparam logic [15:0] UNR = 16'h0105;

  logic clk = 0, rst_n = 0;
  logic busy_n = 1, own_cycle = 1, io_cycle = 0;
  logic prot_err_n = 1, par_err_n = 1, addr_err_n = 1;
  logic sysflt0 = 0, sysflt1 = 0, clr_stb = 0;
  logic [15:0] fault_q;
  logic pending, major_err, unrcv_err;
  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  bus_fault_reg uut (
    .clk(clk), .rst_n(rst_n), .busy_n(busy_n), .own_cycle(own_cycle),
    .io_cycle(io_cycle), .prot_err_n(prot_err_n), .par_err_n(par_err_n),
    .addr_err_n(addr_err_n), .sysflt0(sysflt0), .sysflt1(sysflt1),
    .clr_stb(clr_stb), .fault_q(fault_q), .pending(pending),
    .major_err(major_err), .unrcv_err(unrcv_err)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check_all(input logic [15:0] exp, input string req);
    checks++;
    if (fault_q !== exp) begin
      failures++;
      $display("FAIL %s fault_q actual=%h expected=%h", req, fault_q, exp);
    end
    checks++;
    if (pending !== (exp != 0)) begin
      failures++;
      $display("FAIL R10 pending actual=%b expected=%b", pending, exp != 0);
    end
    checks++;
    if (major_err !== ((exp & MAJ) != 0) || unrcv_err !== ((exp & UNR) != 0)) begin
      failures++;
      $display("FAIL R11 major/unrcv actual=%b%b expected=%b%b", major_err, unrcv_err,
               (exp & MAJ) != 0, (exp & UNR) != 0);
    end
  endtask

  task automatic bus_cycle(input logic own, input logic io, input logic prot,
                           input logic par, input logic adr, input logic clr);
    @(negedge clk);
    busy_n = 0; own_cycle = own; io_cycle = io;
    prot_err_n = ~prot; par_err_n = ~par; addr_err_n = ~adr;
    @(negedge clk);
    @(negedge clk);
    busy_n = 1; clr_stb = clr;
    @(negedge clk);
    clr_stb = 0; prot_err_n = 1; par_err_n = 1; addr_err_n = 1;
  endtask

  task automatic do_clear();
    @(negedge clk); clr_stb = 1;
    @(negedge clk); clr_stb = 0;
    check_all(16'h0000, "R8 clear");
  endtask

  task automatic t_reset();
    check_all(16'h0000, "R1");
  endtask

  task automatic t_protect();
    bus_cycle(1, 0, 1, 0, 0, 0);
    check_all(16'h8000, "R3 own");
    do_clear();
    bus_cycle(0, 0, 1, 0, 0, 0);
    check_all(16'h4000, "R3 non-own");
    do_clear();
  endtask

  task automatic t_parity();
    bus_cycle(0, 1, 0, 1, 0, 0);
    check_all(16'h2000, "R4 non-own io");
    do_clear();
    bus_cycle(1, 0, 0, 1, 0, 0);
    check_all(16'h2000, "R4 own mem");
    do_clear();
  endtask

  task automatic t_address();
    bus_cycle(0, 0, 0, 0, 1, 0);
    check_all(16'h0400, "R5 mem");
    do_clear();
    bus_cycle(1, 1, 0, 0, 1, 0);
    check_all(16'h0080, "R5 io");
    do_clear();
  endtask

  task automatic t_multi();
    bus_cycle(1, 1, 1, 1, 1, 0);
    check_all(16'hA080, "R12");
    bus_cycle(0, 0, 1, 0, 1, 0);
    check_all(16'hE480, "R12 accumulate");
    do_clear();
  endtask

  task automatic t_no_edge();
    @(negedge clk);
    prot_err_n = 0; par_err_n = 0; addr_err_n = 0;
    for (int i = 0; i < 4; i++) @(negedge clk);
    check_all(16'h0000, "R2 busy high");
    busy_n = 0;
    for (int i = 0; i < 4; i++) @(negedge clk);
    check_all(16'h0000, "R2 busy low");
    prot_err_n = 1; par_err_n = 1; addr_err_n = 1;
    @(negedge clk); busy_n = 1;
    @(negedge clk);
    check_all(16'h0000, "R2 quiet end");
  endtask

  task automatic t_sticky();
    bus_cycle(0, 0, 1, 0, 0, 0);
    for (int i = 0; i < 6; i++) @(negedge clk);
    check_all(16'h4000, "R8 sticky");
  endtask

  task automatic t_race();
    bus_cycle(0, 0, 0, 1, 0, 1);
    check_all(16'h2000, "R9");
    do_clear();
  endtask

  task automatic t_sys0();
    @(negedge clk); sysflt0 = 1;
    @(negedge clk); @(negedge clk);
    check_all(16'h0000, "R6 latency");
    @(negedge clk);
    check_all(16'h0100, "R6");
    do_clear();
    for (int i = 0; i < 4; i++) @(negedge clk);
    check_all(16'h0000, "R6 level held");
    sysflt0 = 0;
    for (int i = 0; i < 3; i++) @(negedge clk);
  endtask

  task automatic t_sys1();
    @(negedge clk); sysflt1 = 1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    check_all(16'h0005, "R7");
    sysflt1 = 0;
    do_clear();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_protect();
    t_parity();
    t_address();
    t_multi();
    t_no_edge();
    t_sticky();
    t_race();
    t_sys0();
    t_sys1();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule